// File: doc/BRIEF.md
# Serial Control Register Bank with Timed Power Switching

This block is the control front end of a radio interface. A host writes 24-bit words over three wires: a serial clock, a data line and a latch line. Each word carries a 3-bit register address in its low bits and 21 bits of data above it. The word is stored in one of eight registers when the latch line pulses after exactly 24 clock pulses. All three serial lines are sampled through synchronisers in the block's own clock domain, so the host's serial clock may be slow and unrelated to it.

A power-command register stages power-mode changes. A command loaded while the power strobe is low takes effect only when the strobe next rises, which lets the host time mode changes exactly. The alternate receive/transmit mode is the exception: it applies at the latch, and from then on the strobe level alone picks receive or transmit. A calibrate-start bit clears itself once an external calibration engine reports a result, and the 4-bit result code is kept beside it. The block also merges an external lock indication with the receive or transmit synthesiser lock.

Top module: `tw_ctl_bank`

## Requirements
- R1: After reset (rst_ni low) every register reads zero on cfg_o, and cal_start_o, lock select, bias_en_o, rx_en_o, tx_en_o, rssi_en_o, rxpll_en_o and txpll_en_o are all 0.
- R2: A word is shifted in MSB first, one bit per rising edge of sclk_i, sampling sdata_i. On a rising slatch_i after exactly 24 edges, word bits [2:0] select a register and bits [23:3] are stored at cfg_o[addr*21 +: 21].
- R3: A latch after fewer or more than 24 clock edges writes no register and changes no output.
- R4: A power command (register 6, data bits [3:0]) other than alternate mode is held pending and changes no enable until pca_i rises; then it is applied once.
- R5: Command 5 (alternate) applies at the latch without a strobe. While it is active, rx_en_o equals not pca_i and tx_en_o equals pca_i, with bias_en_o high.
- R6: Commands 0 to 4 select deep sleep, standby, transmit, receive and duplex. Deep sleep drives every enable low. Standby sets only bias_en_o. Transmit sets tx_en_o, receive sets rx_en_o, duplex sets both, each with bias_en_o.
- R7: Commands 6/7 set/clear RSSI keep, 8/9 transmit PLL keep, and 10/11 receive PLL keep. rssi_en_o is rx_en_o AND RSSI keep. rxpll_en_o is bias_en_o AND (rx_en_o OR receive PLL keep), and txpll_en_o is the same for transmit. The commands do not change the main mode.
- R8: Register 5 data bit 0 is the calibrate-start bit, shown on cal_start_o. When cal_done_i is high while it is set, the bit clears and cal_code_i is stored in register 5 data bits [4:1]. cal_done_i while the bit is clear has no effect.
- R9: lock_o is uhf_lock_i AND the receive lock (register 4 data bit 0 = 0) or the transmit lock (bit 0 = 1).
- R10: Command codes 12 to 15 leave every enable unchanged, even after a strobe rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | Serial bit clock |
| sdata_i | input | 1 | Serial data, MSB first |
| slatch_i | input | 1 | Word transfer pulse |
| pca_i | input | 1 | Power-change strobe |
| uhf_lock_i | input | 1 | Lock from the external synthesiser |
| rx_lock_i | input | 1 | Receive synthesiser lock |
| tx_lock_i | input | 1 | Transmit synthesiser lock |
| cal_done_i | input | 1 | Calibration result valid |
| cal_code_i | input | 4 | Calibration result |
| cfg_o | output | 168 | Eight 21-bit register contents, register n at [n*21 +: 21] |
| cal_start_o | output | 1 | Calibration request |
| lock_o | output | 1 | Combined lock |
| bias_en_o | output | 1 | Reference and bias enable |
| rx_en_o | output | 1 | Receive chain enable |
| tx_en_o | output | 1 | Transmit chain enable |
| rssi_en_o | output | 1 | Signal-strength circuit enable |
| rxpll_en_o | output | 1 | Receive PLL enable |
| txpll_en_o | output | 1 | Transmit PLL enable |

## Verification
Words are written to registers with different addresses and with all-ones, alternating and sparse data. A wrong bit order, an address decode error or a slice offset shows up as a mismatch in a particular register. Latches after 23 and 25 clock edges tell an exact-count rule apart from an at-least or at-most rule. Power commands are sent with the strobe held low and then raised, which separates staged application from immediate application. The alternate mode is toggled through both strobe levels. All eight lock input combinations are applied under both select values. Calibration-done pulses are sent with the start bit clear and with it set, which shows whether the self-clear depends on the bit.

// File: rtl/tw_ctl_pkg.sv
package tw_ctl_pkg;
  localparam int WORD_W  = 24;
  localparam int ADDR_W  = 3;
  localparam int N_REGS  = 1 << ADDR_W;
  localparam int DATA_W  = WORD_W - ADDR_W;
  localparam int CODE_W  = 4;
  localparam int CMD_W   = 4;

  localparam int LOCK_REG = 4;
  localparam int CAL_REG  = 5;
  localparam int PWR_REG  = 6;
  localparam int LOCK_BIT = 0;
  localparam int CAL_BIT  = 0;
  localparam int CODE_LSB = 1;

  typedef enum logic [CMD_W-1:0] {
    CMD_SLEEP     = 4'd0,
    CMD_STBY      = 4'd1,
    CMD_TX        = 4'd2,
    CMD_RX        = 4'd3,
    CMD_DUPLEX    = 4'd4,
    CMD_ALT       = 4'd5,
    CMD_RSSI_ON   = 4'd6,
    CMD_RSSI_OFF  = 4'd7,
    CMD_TXPLL_ON  = 4'd8,
    CMD_TXPLL_OFF = 4'd9,
    CMD_RXPLL_ON  = 4'd10,
    CMD_RXPLL_OFF = 4'd11
  } pwr_cmd_e;

  typedef enum logic [2:0] {
    M_SLEEP, M_STBY, M_TX, M_RX, M_DUPLEX, M_ALT
  } pwr_mode_e;
endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] st_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) st_q[s] <= '0;
      else if (s == 0) st_q[s] <= d_i;
      else st_q[s] <= st_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/tw_shift.sv
module tw_shift
  import tw_ctl_pkg::*;
#(
  parameter int WW = WORD_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sclk_i,
  input  logic          sdata_i,
  input  logic          slatch_i,
  output logic          wr_o,
  output logic [WW-1:0] word_o
);
  localparam int CNT_W = $clog2(WW + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WW);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(WW + 1);

  logic          sclk_q, slatch_q;
  logic [WW-1:0] sh_q;
  logic [CNT_W-1:0] cnt_q;
  logic          sclk_rise, latch_rise;

  assign sclk_rise  = sclk_i & ~sclk_q;
  assign latch_rise = slatch_i & ~slatch_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q   <= 1'b0;
      slatch_q <= 1'b0;
      sh_q     <= '0;
      cnt_q    <= '0;
      wr_o     <= 1'b0;
      word_o   <= '0;
    end else begin
      sclk_q   <= sclk_i;
      slatch_q <= slatch_i;
      wr_o     <= 1'b0;
      if (latch_rise) begin
        // only an exact-length word is accepted
        wr_o   <= (cnt_q == CNT_FULL);
        word_o <= sh_q;
        cnt_q  <= '0;
      end else if (sclk_rise) begin
        sh_q  <= {sh_q[WW-2:0], sdata_i};
        cnt_q <= (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/tw_regs.sv
module tw_regs
  import tw_ctl_pkg::*;
(
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [DATA_W-1:0]        data_i,
  input  logic                     cal_done_i,
  input  logic [CODE_W-1:0]        cal_code_i,
  output logic [N_REGS*DATA_W-1:0] cfg_o,
  output logic                     lock_sel_o,
  output logic                     cal_start_o
);
  logic [DATA_W-1:0] regs_q [N_REGS];

  for (genvar g = 0; g < N_REGS; g++) begin : g_reg
    if (g == CAL_REG) begin : g_cal
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) regs_q[g] <= '0;
        else if (wr_i && addr_i == ADDR_W'(g)) regs_q[g] <= data_i;
        else if (cal_done_i && regs_q[g][CAL_BIT]) begin
          regs_q[g][CAL_BIT] <= 1'b0;
          regs_q[g][CODE_LSB +: CODE_W] <= cal_code_i;
        end
      end
    end else begin : g_plain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) regs_q[g] <= '0;
        else if (wr_i && addr_i == ADDR_W'(g)) regs_q[g] <= data_i;
      end
    end
    assign cfg_o[g*DATA_W +: DATA_W] = regs_q[g];
  end

  assign lock_sel_o  = regs_q[LOCK_REG][LOCK_BIT];
  assign cal_start_o = regs_q[CAL_REG][CAL_BIT];
endmodule

// File: rtl/tw_pwr.sv
module tw_pwr
  import tw_ctl_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pca_i,
  input  logic             wr_i,
  input  logic [CMD_W-1:0] cmd_i,
  output logic             pca_rise_o,
  output logic             bias_en_o,
  output logic             rx_en_o,
  output logic             tx_en_o,
  output logic             rssi_en_o,
  output logic             rxpll_en_o,
  output logic             txpll_en_o
);
  pwr_mode_e        mode_q;
  logic             pca_q, pend_q;
  logic [CMD_W-1:0] pend_cmd_q;
  logic             rssi_k_q, rxpll_k_q, txpll_k_q;

  assign pca_rise_o = pca_i & ~pca_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q     <= M_SLEEP;
      pca_q      <= 1'b0;
      pend_q     <= 1'b0;
      pend_cmd_q <= '0;
      rssi_k_q   <= 1'b0;
      rxpll_k_q  <= 1'b0;
      txpll_k_q  <= 1'b0;
    end else begin
      pca_q <= pca_i;
      if (wr_i) begin
        if (cmd_i == CMD_ALT) begin
          mode_q <= M_ALT;
          pend_q <= 1'b0;
        end else begin
          pend_q     <= 1'b1;
          pend_cmd_q <= cmd_i;
        end
      end else if (pca_rise_o && pend_q) begin
        pend_q <= 1'b0;
        case (pend_cmd_q)
          CMD_SLEEP:     mode_q <= M_SLEEP;
          CMD_STBY:      mode_q <= M_STBY;
          CMD_TX:        mode_q <= M_TX;
          CMD_RX:        mode_q <= M_RX;
          CMD_DUPLEX:    mode_q <= M_DUPLEX;
          CMD_RSSI_ON:   rssi_k_q  <= 1'b1;
          CMD_RSSI_OFF:  rssi_k_q  <= 1'b0;
          CMD_TXPLL_ON:  txpll_k_q <= 1'b1;
          CMD_TXPLL_OFF: txpll_k_q <= 1'b0;
          CMD_RXPLL_ON:  rxpll_k_q <= 1'b1;
          CMD_RXPLL_OFF: rxpll_k_q <= 1'b0;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    bias_en_o  = (mode_q != M_SLEEP);
    rx_en_o    = (mode_q == M_RX) || (mode_q == M_DUPLEX) || (mode_q == M_ALT && !pca_i);
    tx_en_o    = (mode_q == M_TX) || (mode_q == M_DUPLEX) || (mode_q == M_ALT && pca_i);
    rssi_en_o  = rx_en_o && rssi_k_q;
    rxpll_en_o = bias_en_o && (rx_en_o || rxpll_k_q);
    txpll_en_o = bias_en_o && (tx_en_o || txpll_k_q);
  end
endmodule

// File: rtl/tw_ctl_bank.sv
module tw_ctl_bank
  import tw_ctl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     sclk_i,
  input  logic                     sdata_i,
  input  logic                     slatch_i,
  input  logic                     pca_i,
  input  logic                     uhf_lock_i,
  input  logic                     rx_lock_i,
  input  logic                     tx_lock_i,
  input  logic                     cal_done_i,
  input  logic [CODE_W-1:0]        cal_code_i,
  output logic [N_REGS*DATA_W-1:0] cfg_o,
  output logic                     cal_start_o,
  output logic                     lock_o,
  output logic                     bias_en_o,
  output logic                     rx_en_o,
  output logic                     tx_en_o,
  output logic                     rssi_en_o,
  output logic                     rxpll_en_o,
  output logic                     txpll_en_o
);
  logic [3:0]        sync_q;
  logic              wr_vld;
  logic [WORD_W-1:0] wr_word;
  logic              lock_sel;
  logic              pca_rise;

  tw_sync #(.W(4), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({pca_i, slatch_i, sdata_i, sclk_i}),
    .q_o   (sync_q)
  );

  tw_shift u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sclk_i  (sync_q[0]),
    .sdata_i (sync_q[1]),
    .slatch_i(sync_q[2]),
    .wr_o    (wr_vld),
    .word_o  (wr_word)
  );

  tw_regs u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (wr_vld),
    .addr_i     (wr_word[ADDR_W-1:0]),
    .data_i     (wr_word[WORD_W-1:ADDR_W]),
    .cal_done_i (cal_done_i),
    .cal_code_i (cal_code_i),
    .cfg_o      (cfg_o),
    .lock_sel_o (lock_sel),
    .cal_start_o(cal_start_o)
  );

  tw_pwr u_pwr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pca_i     (sync_q[3]),
    .wr_i      (wr_vld && wr_word[ADDR_W-1:0] == ADDR_W'(PWR_REG)),
    .cmd_i     (wr_word[ADDR_W +: CMD_W]),
    .pca_rise_o(pca_rise),
    .bias_en_o (bias_en_o),
    .rx_en_o   (rx_en_o),
    .tx_en_o   (tx_en_o),
    .rssi_en_o (rssi_en_o),
    .rxpll_en_o(rxpll_en_o),
    .txpll_en_o(txpll_en_o)
  );

  assign lock_o = uhf_lock_i & (lock_sel ? tx_lock_i : rx_lock_i);
endmodule

// File: rtl/tw_ctl_chk.sv
module tw_ctl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic uhf_lock_i,
  input logic rx_lock_i,
  input logic tx_lock_i,
  input logic lock_o,
  input logic cal_start_o,
  input logic cal_done_i,
  input logic wr_vld,
  input logic pca_rise,
  input logic bias_en_o,
  input logic rx_en_o,
  input logic tx_en_o,
  input logic rssi_en_o,
  input logic rxpll_en_o,
  input logic txpll_en_o
);
  p_lock_uhf_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !uhf_lock_i |-> !lock_o);
  p_lock_none_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rx_lock_i && !tx_lock_i) |-> !lock_o);
  p_cal_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cal_start_o && cal_done_i && !wr_vld) |=> !cal_start_o);
  p_staged_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_vld && !pca_rise) |=> $stable(bias_en_o));
  p_sleep_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bias_en_o |-> (!rx_en_o && !tx_en_o && !rxpll_en_o && !txpll_en_o));
  p_rssi_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rssi_en_o |-> rx_en_o);
endmodule

bind tw_ctl_bank tw_ctl_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .uhf_lock_i (uhf_lock_i),
  .rx_lock_i  (rx_lock_i),
  .tx_lock_i  (tx_lock_i),
  .lock_o     (lock_o),
  .cal_start_o(cal_start_o),
  .cal_done_i (cal_done_i),
  .wr_vld     (wr_vld),
  .pca_rise   (pca_rise),
  .bias_en_o  (bias_en_o),
  .rx_en_o    (rx_en_o),
  .tx_en_o    (tx_en_o),
  .rssi_en_o  (rssi_en_o),
  .rxpll_en_o (rxpll_en_o),
  .txpll_en_o (txpll_en_o)
);

// File: tb/tw_ctl_bank_test.sv
module tw_ctl_bank_test;
  logic clk = 0, rst_ni = 0;
  logic sclk = 0, sdata = 0, slatch = 0, pca = 0;
  logic uhf = 0, rxl = 0, txl = 0, cal_done = 0;
  logic [3:0] cal_code = 0;
  logic [167:0] cfg;
  logic cal_start, lock, bias, rxe, txe, rssie, rxpe, txpe;

  always #10 clk = ~clk;

  tw_ctl_bank uut (
    .clk_i(clk), .rst_ni(rst_ni), .sclk_i(sclk), .sdata_i(sdata), .slatch_i(slatch),
    .pca_i(pca), .uhf_lock_i(uhf), .rx_lock_i(rxl), .tx_lock_i(txl),
    .cal_done_i(cal_done), .cal_code_i(cal_code), .cfg_o(cfg), .cal_start_o(cal_start),
    .lock_o(lock), .bias_en_o(bias), .rx_en_o(rxe), .tx_en_o(txe), .rssi_en_o(rssie),
    .rxpll_en_o(rxpe), .txpll_en_o(txpe)
  );

  int checks = 0, errors = 0;
  bit settled = 0, done = 0;
  string cur_req = "R1";

  // reference model
  logic [20:0] m_reg [8];
  int m_mode = 0;
  bit m_pend = 0;
  int m_pcmd = 0;
  bit m_rk = 0, m_rxk = 0, m_txk = 0;

  task automatic chk(string what, logic [167:0] got, logic [167:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", cur_req, what, got, exp);
    end
  endtask

  function automatic logic [167:0] exp_cfg();
    logic [167:0] v;
    for (int i = 0; i < 8; i++) v[i*21 +: 21] = m_reg[i];
    return v;
  endfunction

  task automatic compare_all();
    bit e_bias, e_rx, e_tx, e_lsel;
    e_bias = (m_mode != 0);
    e_rx = (m_mode == 3) || (m_mode == 4) || (m_mode == 5 && !pca);
    e_tx = (m_mode == 2) || (m_mode == 4) || (m_mode == 5 && pca);
    e_lsel = m_reg[4][0];
    chk("cfg", cfg, exp_cfg());
    chk("cal_start", 168'(cal_start), 168'(m_reg[5][0]));
    chk("lock", 168'(lock), 168'(uhf & (e_lsel ? txl : rxl)));
    chk("bias", 168'(bias), 168'(e_bias));
    chk("rx_en", 168'(rxe), 168'(e_rx));
    chk("tx_en", 168'(txe), 168'(e_tx));
    chk("rssi_en", 168'(rssie), 168'(e_rx && m_rk));
    chk("rxpll_en", 168'(rxpe), 168'(e_bias && (e_rx || m_rxk)));
    chk("txpll_en", 168'(txpe), 168'(e_bias && (e_tx || m_txk)));
  endtask

  // every-cycle comparison while the model is in step
  always @(negedge clk) if (settled && !done) compare_all();

  task automatic clks(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic settle();
    clks(8);
    settled = 1;
  endtask

  // send nbits ending with word bit 0; extra leading bits are zero
  task automatic ser(int addr, logic [20:0] data, int nbits);
    logic [23:0] w;
    w = {data, 3'(addr)};
    settled = 0;
    for (int i = nbits - 1; i >= 0; i--) begin
      sdata = (i < 24) ? w[i] : 1'b0;
      clks(3); sclk = 1; clks(3); sclk = 0; clks(2);
    end
    clks(2); slatch = 1; clks(3); slatch = 0;
    if (nbits == 24) begin
      m_reg[addr] = data;
      if (addr == 6) begin
        if (data[3:0] == 4'd5) begin m_mode = 5; m_pend = 0; end
        else begin m_pend = 1; m_pcmd = int'(data[3:0]); end
      end
    end
    settle();
  endtask

  task automatic set_pca(bit v);
    settled = 0;
    if (v && !pca && m_pend) begin
      m_pend = 0;
      case (m_pcmd)
        0, 1, 2, 3, 4: m_mode = m_pcmd;
        6: m_rk = 1;  7: m_rk = 0;
        8: m_txk = 1; 9: m_txk = 0;
        10: m_rxk = 1; 11: m_rxk = 0;
        default: ;
      endcase
    end
    pca = v;
    settle();
  endtask

  task automatic pulse_pca();
    set_pca(1); set_pca(0);
  endtask

  task automatic cal_pulse(logic [3:0] code);
    settled = 0;
    cal_done = 1; cal_code = code;
    clks(1);
    cal_done = 0;
    if (m_reg[5][0]) begin m_reg[5][0] = 0; m_reg[5][4:1] = code; end
    settle();
  endtask

  task automatic expect_bit(string what, logic got, logic exp);
    chk(what, 168'(got), 168'(exp));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) m_reg[i] = '0;
    clks(3);
    cur_req = "R1";
    compare_all();
    rst_ni = 1;
    settle();
    expect_bit("R1 bias after reset", bias, 1'b0);

    cur_req = "R2";
    ser(0, 21'h1ABCDE, 24);
    ser(7, 21'h1FFFFF, 24);
    ser(3, 21'h0AAAAA, 24);
    ser(1, 21'h000001, 24);
    ser(2, 21'h100000, 24);
    chk("R2 reg7 slice", 168'(cfg[7*21 +: 21]), 168'(21'h1FFFFF));

    cur_req = "R3";
    ser(1, 21'h155555, 23);
    ser(1, 21'h0F0F0F, 25);
    ser(6, 21'h000003, 23);
    pulse_pca();
    chk("R3 reg1 kept", 168'(cfg[21 +: 21]), 168'(21'h000001));

    cur_req = "R9";
    for (int s = 0; s < 2; s++) begin
      ser(4, 21'(s), 24);
      for (int k = 0; k < 8; k++) begin
        {uhf, rxl, txl} = 3'(k);
        clks(2);
        expect_bit("R9 lock", lock, uhf & (s[0] ? txl : rxl));
      end
    end

    cur_req = "R8";
    ser(5, 21'h000000, 24);
    cal_pulse(4'h7);
    ser(5, 21'h1F0001, 24);
    expect_bit("R8 start set", cal_start, 1'b1);
    cal_pulse(4'hA);
    expect_bit("R8 start cleared", cal_start, 1'b0);
    chk("R8 code", 168'(cfg[5*21 +: 21]), 168'(21'h1F0014));

    cur_req = "R4";
    ser(6, 21'h000003, 24);
    expect_bit("R4 rx still off", rxe, 1'b0);
    pulse_pca();
    expect_bit("R4 rx on", rxe, 1'b1);
    ser(6, 21'h000002, 24);
    expect_bit("R4 rx held", rxe, 1'b1);
    pulse_pca();
    expect_bit("R4 tx on", txe, 1'b1);
    pulse_pca();

    cur_req = "R6";
    ser(6, 21'h000004, 24); pulse_pca();
    ser(6, 21'h000001, 24); pulse_pca();
    expect_bit("R6 standby bias", bias, 1'b1);
    ser(6, 21'h000000, 24); pulse_pca();
    expect_bit("R6 sleep bias", bias, 1'b0);

    cur_req = "R7";
    ser(6, 21'h00000A, 24); pulse_pca();
    ser(6, 21'h000001, 24); pulse_pca();
    expect_bit("R7 rxpll keep", rxpe, 1'b1);
    ser(6, 21'h000006, 24); pulse_pca();
    ser(6, 21'h000008, 24); pulse_pca();
    ser(6, 21'h000003, 24); pulse_pca();
    expect_bit("R7 rssi", rssie, 1'b1);
    ser(6, 21'h000007, 24); pulse_pca();
    ser(6, 21'h00000B, 24); pulse_pca();
    ser(6, 21'h000009, 24); pulse_pca();

    cur_req = "R5";
    ser(6, 21'h000005, 24);
    expect_bit("R5 rx at latch", rxe, 1'b1);
    set_pca(1);
    expect_bit("R5 tx high strobe", txe, 1'b1);
    set_pca(0);
    set_pca(1);
    set_pca(0);
    expect_bit("R5 rx low strobe", rxe, 1'b1);

    cur_req = "R10";
    ser(6, 21'h000002, 24); pulse_pca();
    for (int c = 12; c < 16; c++) begin
      ser(6, 21'(c), 24);
      pulse_pca();
    end
    expect_bit("R10 tx unchanged", txe, 1'b1);

    cur_req = "R1";
    settled = 0;
    rst_ni = 0;
    for (int i = 0; i < 8; i++) m_reg[i] = '0;
    m_mode = 0; m_pend = 0; m_rk = 0; m_rxk = 0; m_txk = 0;
    clks(2);
    compare_all();
    rst_ni = 1;
    settle();

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule